// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets software on any of up to four CPUs ring doorbells on other CPUs. A write to a shared trigger register carries a doorbell number in its low byte and a target-CPU bitmap in the byte above it. Every CPU named in the bitmap gets the matching bit set in its pending-doorbell register, and all of them are set on the same clock edge.

Each CPU reaches its own pending and enable registers through a local register window. The bus supplies a CPU index with each local access. A CPU clears its doorbells by writing its pending register, and that write replaces the whole register. For each CPU the block drives a registered request line. The line is high when at least one enabled doorbell is pending and that CPU's interrupt-controller mask for source 0 is clear.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every pending bit, every enable bit, every request line and the read data are zero.
- R2: A write to global offset 0x4 with doorbell number n (bits [7:0]) below 8 sets pending bit n of each CPU c whose bitmap bit 8+c is 1. All other pending bits keep their values, and several CPUs are updated in the same cycle.
- R3: A trigger write whose number is 8 or above changes no pending bit. Bitmap bits 8+c for c at or above the CPU count have no effect.
- R4: A local write to offset 0x8 replaces that CPU's pending register with bits [7:0] of the write data, so writing zero clears every pending doorbell of that CPU.
- R5: A local write to offset 0xC sets that CPU's 8-bit enable register, and 0xFF enables all eight doorbells.
- R6: Request line c is the OR over the eight doorbells of (pending AND enable), gated off while mask input c is 1. It is registered, so it follows the pending and enable state one cycle after that state changes.
- R7: A local read of offset 0x8 or 0xC returns that CPU's pending or enable value in bits [7:0] and zero above. The data and `bus_rvalid` appear one cycle after the read. Reads of any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel_local | input | 1 | 1 = per-CPU window, 0 = global window |
| bus_cpu | input | 2 | CPU index for per-CPU accesses |
| bus_addr | input | 8 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_mask_id0 | input | 4 | Per-CPU interrupt-controller mask for source 0 (1 = masked) |
| doorbell_irq | output | 4 | Registered per-CPU doorbell request |

## Verification
The tests use single-target and multi-target bitmaps, which show whether one trigger write updates several CPUs at once and leaves untargeted CPUs alone. They also use doorbell numbers of 8 and up and bitmap bits above the fourth CPU, which show whether out-of-range fields are really discarded. Enable patterns that do and do not overlap the pending bits separate a true AND-then-OR from a plain OR of pending bits. The mask input is toggled to show that the source-0 gate works. Replacing writes, clearing writes and accesses to unmapped offsets show whether a cause write ORs or replaces, and whether decoding is exact.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int DB_COUNT  = 8;
  localparam int MAP_LSB   = 8;
  localparam logic [7:0] OFS_TRIG  = 8'h04;
  localparam logic [7:0] OFS_CAUSE = 8'h08;
  localparam logic [7:0] OFS_EN    = 8'h0C;

  typedef struct packed {
    logic trig;
    logic cause_we;
    logic en_we;
    logic cause_re;
    logic en_re;
  } db_dec_t;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel_local,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  output db_dec_t           dec
);
  logic cpu_ok;
  logic local_hit;

  assign cpu_ok    = ({1'b0, bus_cpu} < (CPU_W+1)'(NCPU));
  assign local_hit = bus_sel_local && cpu_ok;

  always_comb begin
    dec          = '0;
    dec.trig     = bus_wr && !bus_sel_local && (bus_addr == ADDR_W'(OFS_TRIG));
    dec.cause_we = bus_wr && local_hit && (bus_addr == ADDR_W'(OFS_CAUSE));
    dec.en_we    = bus_wr && local_hit && (bus_addr == ADDR_W'(OFS_EN));
    dec.cause_re = bus_rd && local_hit && (bus_addr == ADDR_W'(OFS_CAUSE));
    dec.en_re    = bus_rd && local_hit && (bus_addr == ADDR_W'(OFS_EN));
  end
endmodule

// File: rtl/doorbell_cpu_bank.sv
module doorbell_cpu_bank #(
  parameter int NDB = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NDB-1:0] set_vec,
  input  logic           cause_we,
  input  logic           en_we,
  input  logic [NDB-1:0] wval,
  input  logic           gate_off,
  output logic [NDB-1:0] cause_q,
  output logic [NDB-1:0] en_q,
  output logic           req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      en_q    <= '0;
      req_q   <= 1'b0;
    end else begin
      if (cause_we) cause_q <= wval | set_vec;
      else          cause_q <= cause_q | set_vec;
      if (en_we)    en_q    <= wval;
      req_q <= (|(cause_q & en_q)) && !gate_off;
    end
  end
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int NDB   = DB_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel_local,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NCPU-1:0]   irq_mask_id0,
  output logic [NCPU-1:0]   doorbell_irq
);
  db_dec_t dec;
  logic [7:0]          trig_num;
  logic [NCPU-1:0]     trig_map;
  logic [NDB-1:0]      cause_arr [NCPU];
  logic [NDB-1:0]      en_arr    [NCPU];
  logic [NCPU*NDB-1:0] cause_flat;
  logic [NCPU*NDB-1:0] en_flat;
  logic                unused_hi;

  assign trig_num  = bus_wdata[7:0];
  assign trig_map  = bus_wdata[MAP_LSB +: NCPU];
  assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:MAP_LSB+NCPU]};

  doorbell_decode #(.NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_sel_local(bus_sel_local),
    .bus_cpu      (bus_cpu),
    .bus_addr     (bus_addr),
    .dec          (dec)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NDB-1:0] set_vec;
    logic           sel;
    assign sel = (bus_cpu == CPU_W'(c));
    for (genvar b = 0; b < NDB; b++) begin : g_bit
      assign set_vec[b] = dec.trig && trig_map[c] && (trig_num == 8'(b));
    end
    doorbell_cpu_bank #(.NDB(NDB)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec),
      .cause_we(dec.cause_we && sel),
      .en_we   (dec.en_we && sel),
      .wval    (bus_wdata[NDB-1:0]),
      .gate_off(irq_mask_id0[c]),
      .cause_q (cause_arr[c]),
      .en_q    (en_arr[c]),
      .req_q   (doorbell_irq[c])
    );
    assign cause_flat[c*NDB +: NDB] = cause_arr[c];
    assign en_flat[c*NDB +: NDB]    = en_arr[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= '0;
      if (dec.cause_re)   bus_rdata[NDB-1:0] <= cause_arr[bus_cpu];
      else if (dec.en_re) bus_rdata[NDB-1:0] <= en_arr[bus_cpu];
    end
  end
endmodule

// File: rtl/doorbell_unit_chk.sv
module doorbell_unit_chk
  import doorbell_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 8,
  parameter int NDB    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_sel_local,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        wlo,
  input logic [NCPU-1:0]   wmap,
  input logic [NCPU-1:0]   irq_mask_id0,
  input logic [NCPU-1:0]   doorbell_irq,
  input logic [NCPU*NDB-1:0] cause_flat,
  input logic [NCPU*NDB-1:0] en_flat
);
  logic trig_w;
  assign trig_w = bus_wr && !bus_sel_local && (bus_addr == ADDR_W'(OFS_TRIG));

  assert_bad_num_R3: assert property (@(posedge clk) disable iff (rst)
    (trig_w && (wlo >= 8'(NDB))) |=> $stable(cause_flat));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    assert_cause_replace_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_sel_local && bus_cpu == CPU_W'(c) && bus_addr == ADDR_W'(OFS_CAUSE))
      |=> (cause_flat[c*NDB +: NDB] == $past(wlo[NDB-1:0])));
    assert_en_write_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_sel_local && bus_cpu == CPU_W'(c) && bus_addr == ADDR_W'(OFS_EN))
      |=> (en_flat[c*NDB +: NDB] == $past(wlo[NDB-1:0])));
    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
      irq_mask_id0[c] |=> !doorbell_irq[c]);
    for (genvar b = 0; b < NDB; b++) begin : g_b
      assert_trig_set_R2: assert property (@(posedge clk) disable iff (rst)
        (trig_w && wmap[c] && wlo == 8'(b)) |=> cause_flat[c*NDB + b]);
    end
  end
endmodule

bind doorbell_unit doorbell_unit_chk #(.NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .NDB(NDB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_sel_local(bus_sel_local),
  .bus_cpu     (bus_cpu),
  .bus_addr    (bus_addr),
  .wlo         (bus_wdata[7:0]),
  .wmap        (bus_wdata[8 +: NCPU]),
  .irq_mask_id0(irq_mask_id0),
  .doorbell_irq(doorbell_irq),
  .cause_flat  (cause_flat),
  .en_flat     (en_flat)
);

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_sel_local = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  irq_mask_id0 = '0;
  logic [3:0]  doorbell_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_cause [4];
  logic [7:0] m_en    [4];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  doorbell_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_local(bus_sel_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_mask_id0(irq_mask_id0), .doorbell_irq(doorbell_irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      logic [31:0] e;
      string t;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected read data %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s read actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic loc, input int cpu, input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_sel_local = loc; bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    if (!loc && a == 8'h04 && d[7:0] < 8) begin
      for (int c = 0; c < 4; c++) if (d[8+c]) m_cause[c][d[2:0]] = 1'b1;
    end else if (loc && a == 8'h08) m_cause[cpu] = d[7:0];
    else if (loc && a == 8'h0C) m_en[cpu] = d[7:0];
  endtask

  task automatic rd(input int cpu, input logic [7:0] a, input string t);
    logic [31:0] e;
    e = '0;
    if (a == 8'h08) e[7:0] = m_cause[cpu];
    else if (a == 8'h0C) e[7:0] = m_en[cpu];
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_sel_local = 1'b1; bus_cpu = 2'(cpu); bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input string t);
    logic [3:0] e;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 4; c++) e[c] = (|(m_cause[c] & m_en[c])) && !irq_mask_id0[c];
    n_run++;
    if (doorbell_irq !== e) begin
      n_fail++;
      $display("FAIL %s doorbell_irq actual %b expected %b", t, doorbell_irq, e);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_cause[c] = '0; m_en[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_run++;
    if (doorbell_irq !== 4'b0 || bus_rdata !== 32'b0) begin
      n_fail++;
      $display("FAIL R1 outputs actual %b/%h expected 0/0", doorbell_irq, bus_rdata);
    end
    for (int c = 0; c < 4; c++) begin rd(c, 8'h08, "R1"); rd(c, 8'h0C, "R1"); end
    // R2 multi-target trigger, doorbell 3 to CPUs 0 and 2
    wr(1'b0, 0, 8'h04, 32'h0000_0503);
    for (int c = 0; c < 4; c++) rd(c, 8'h08, "R2");
    // R2 broadcast doorbell 7
    wr(1'b0, 0, 8'h04, 32'h0000_0F07);
    for (int c = 0; c < 4; c++) rd(c, 8'h08, "R2");
    // R3 number out of range, and bitmap beyond CPU count
    wr(1'b0, 0, 8'h04, 32'h0000_0F09);
    wr(1'b0, 0, 8'h04, 32'h0000_F001);
    for (int c = 0; c < 4; c++) rd(c, 8'h08, "R3");
    // R5 enables; R6 request: cpu0 all, cpu1 only bit 0 (no overlap with 0x80)
    wr(1'b1, 0, 8'h0C, 32'hFF);
    wr(1'b1, 1, 8'h0C, 32'h01);
    rd(0, 8'h0C, "R5"); rd(1, 8'h0C, "R5");
    chk_irq("R6");
    // R6 mask gating
    irq_mask_id0 = 4'b0001;
    chk_irq("R6");
    irq_mask_id0 = 4'b0000;
    chk_irq("R6");
    // R4 replace and clear
    wr(1'b1, 2, 8'h08, 32'h21);
    rd(2, 8'h08, "R4");
    wr(1'b1, 0, 8'h08, 32'h0);
    rd(0, 8'h08, "R4");
    chk_irq("R4");
    // R7 unmapped offset: write ignored, read zero
    wr(1'b1, 2, 8'h10, 32'hFF);
    rd(2, 8'h10, "R7"); rd(2, 8'h08, "R7"); rd(2, 8'h0C, "R7");
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending reads actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule